// File: doc/BRIEF.md
# Privileged Hardware Register Read Unit

This unit sits beside the execute stage of a CPU and serves the user-mode instruction that reads a small set of architectural hardware registers. Software in privileged mode programs an enable mask; each mask bit opens one register number to unprivileged code. Which mask bits can be set depends on three configuration inputs: performance counters present, user-local register present, and the newer ISA revision. Bits that the configuration does not allow are dropped when the mask is written.

For each read request the unit checks that the register number exists in this configuration and that the caller has the right to read it. The caller has that right if it is privileged or if the matching mask bit is set. A permitted read places the selected value on a registered result bus with a one-cycle valid pulse. A refused read raises a one-cycle reserved-instruction strobe instead and leaves the result bus unchanged. The counters and other sources are outside this unit and arrive as input values. The 3-bit select field arrives already extracted from the instruction word: the standard encoding takes it from bits 8:6 and the compact encoding from bits 13:11.

Top module: `hwreg_read_unit`

## Requirements
- R1: After a synchronous active-low reset, the enable mask is all zeros, `rsp_valid` and `rsp_ri` are low, and `rsp_data` is zero.
- R2: A mask write stores the write data ANDed with the writable set. Bits 0 to 3 are always writable. Every bit other than 0 to 5 and 29 always reads 0. Without a write, the mask holds its value.
- R3: Mask bit 4 takes a 1 only when `cfg_perf_present` and `cfg_rev6` are both high during the write.
- R4: Mask bit 5 takes a 1 only when `cfg_rev6` is high during the write. Mask bit 29 takes a 1 only when `cfg_user_local` is high during the write.
- R5: A read of an implemented register N is permitted when `priv_mode` is high or mask bit N is 1; the mask value used is the one held before any write in the same cycle. Otherwise `rsp_ri` pulses and `rsp_data` keeps its previous value.
- R6: Register 0 returns `src_ebase[9:0]` zero-extended. Register 1 returns `src_sync_step`. Register 3 returns `src_cc_res`.
- R7: Register 2 returns `src_cycle` sign-extended from bit 31 to the result width.
- R8: Register 4 returns `src_perf_ctl0`. It exists only when `cfg_rev6` is high. A nonzero `req_sel` on register 4 raises `rsp_ri`, even in privileged mode.
- R9: Register 5 exists only when `cfg_rev6` is high and returns bit 13 of `src_cfg5` in bit 0, with all other bits zero. Register 29 returns `src_user_local`.
- R10: Register numbers 6 to 28, 30 and 31 raise `rsp_ri` whatever the privilege and mask. So does register 29 when `cfg_user_local` is low.
- R11: Each request cycle gives exactly one of `rsp_valid` or `rsp_ri` on the next cycle. The two are never high together, and neither is high without a request in the previous cycle.
- R12: `req_sel` has no effect on any register other than 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_perf_present | input | 1 | Performance counters are present |
| cfg_user_local | input | 1 | User-local register is present |
| cfg_rev6 | input | 1 | Core implements the newer ISA revision |
| priv_mode | input | 1 | Caller currently has coprocessor-0 rights |
| mask_wr_en | input | 1 | Write strobe for the enable mask |
| mask_wr_data | input | 32 | Enable mask write value |
| mask_q | output | 32 | Current enable mask |
| req_valid | input | 1 | Read request strobe |
| req_reg | input | 5 | Register number to read |
| req_sel | input | 3 | Select field of the instruction |
| src_ebase | input | 32 | Exception-base register; low 10 bits are the CPU number |
| src_sync_step | input | XLEN | Cache-line sync step |
| src_cycle | input | 32 | Cycle counter |
| src_cc_res | input | XLEN | Cycle counter resolution |
| src_perf_ctl0 | input | XLEN | Performance control register 0 |
| src_cfg5 | input | 32 | Configuration register 5 |
| src_user_local | input | XLEN | User-local value |
| rsp_valid | output | 1 | Result valid pulse |
| rsp_ri | output | 1 | Reserved-instruction exception pulse |
| rsp_data | output | XLEN | Registered result |

## Verification
Directed mask writes of all ones under each configuration combination separate the per-bit write conditions, and a write of all ones can only reveal a missing or wrong condition. Reads of register 2 with bit 31 set separate sign extension from zero extension. Reads of register 4 with a nonzero select, and reads of unknown numbers in privileged mode, show that privilege does not bypass the legality check. Seeded random traffic mixes privilege, mask writes in the same cycle as reads, select values and all register numbers. It compares every response and the mask against a bench model, so it catches a unit that reads the mask after the update or that ignores the select field on the wrong register.

// File: rtl/hwr_pkg.sv
// Package: shared constants and types for the hardware register read unit.
// Assumes a 32-bit architectural enable mask indexed by a 5-bit register number.
package hwr_pkg;
    localparam int MASK_W  = 32;
    localparam int REG_W   = $clog2(MASK_W);
    localparam int SEL_W   = 3;

    localparam logic [REG_W-1:0] RN_CPUNUM = 5'd0;
    localparam logic [REG_W-1:0] RN_STEP   = 5'd1;
    localparam logic [REG_W-1:0] RN_CYCLE  = 5'd2;
    localparam logic [REG_W-1:0] RN_RES    = 5'd3;
    localparam logic [REG_W-1:0] RN_PERF   = 5'd4;
    localparam logic [REG_W-1:0] RN_XFLAG  = 5'd5;
    localparam logic [REG_W-1:0] RN_ULOCAL = 5'd29;

    // Configuration conditions that gate mask bits and register existence.
    typedef struct packed {
        logic perf_present;
        logic user_local;
        logic rev6;
    } hwr_cfg_t;
endpackage

// File: rtl/hwr_enable_mask.sv
// Module: enable mask register. Stores software writes filtered by the set of
// bits the current configuration permits; unwritable bits are dropped.
// Assumes: the configuration is sampled in the write cycle.
module hwr_enable_mask
    import hwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  hwr_cfg_t          cfg,
    input  logic              wr_en,
    input  logic [MASK_W-1:0] wr_data,
    output logic [MASK_W-1:0] mask_q
);
    localparam logic [MASK_W-1:0] EVER_WRITABLE = (MASK_W'(1) << RN_ULOCAL) | MASK_W'(32'h3F);

    logic [MASK_W-1:0] writable;

    // Per-bit write permission, one condition per architectural bit.
    for (genvar i = 0; i < MASK_W; i++) begin : g_wr_perm
        if (i < 4) begin : g_always
            assign writable[i] = 1'b1;
        end else if (i == int'(RN_PERF)) begin : g_perf
            assign writable[i] = cfg.perf_present & cfg.rev6;
        end else if (i == int'(RN_XFLAG)) begin : g_xflag
            assign writable[i] = cfg.rev6;
        end else if (i == int'(RN_ULOCAL)) begin : g_ulocal
            assign writable[i] = cfg.user_local;
        end else begin : g_never
            assign writable[i] = 1'b0;
        end
    end

    // Mask register: clear on reset, load filtered data on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= wr_data & writable;
        end
    end

    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(mask_q));
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & ~EVER_WRITABLE) == '0);
    p_bit4_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mask_q[RN_PERF]) |-> $past(cfg.perf_present && cfg.rev6));
    p_bit5_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mask_q[RN_XFLAG]) |-> $past(cfg.rev6));
    p_bit29_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mask_q[RN_ULOCAL]) |-> $past(cfg.user_local));
endmodule

// File: rtl/hwr_access_check.sv
// Module: access checker. Decides whether the requested register exists in
// this configuration and whether the caller may read it.
// Assumes: privilege never makes a missing register readable.
module hwr_access_check
    import hwr_pkg::*;
(
    input  hwr_cfg_t          cfg,
    input  logic              priv,
    input  logic [MASK_W-1:0] mask,
    input  logic [REG_W-1:0]  reg_num,
    input  logic [SEL_W-1:0]  sel,
    output logic              present,
    output logic              permit
);
    // Existence of each register number under the current configuration.
    always_comb begin
        unique case (reg_num)
            RN_CPUNUM, RN_STEP, RN_CYCLE, RN_RES: present = 1'b1;
            RN_PERF:   present = cfg.rev6 && (sel == '0);
            RN_XFLAG:  present = cfg.rev6;
            RN_ULOCAL: present = cfg.user_local;
            default:   present = 1'b0;
        endcase
    end

    // Rights: privileged caller or the enable bit of this register.
    always_comb begin
        permit = present && (priv || mask[reg_num]);
    end
endmodule

// File: rtl/hwr_value_mux.sv
// Module: value selector. Shapes and selects the architectural source value
// for the requested register number.
// Assumes: XLEN is at least 32.
module hwr_value_mux
    import hwr_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int CPUNUM_W = 10,
    parameter int XNP_BIT  = 13
) (
    input  logic [REG_W-1:0] reg_num,
    input  logic [CPUNUM_W-1:0] cpu_num,
    input  logic [XLEN-1:0]  sync_step,
    input  logic [31:0]      cycle,
    input  logic [XLEN-1:0]  cc_res,
    input  logic [XLEN-1:0]  perf_ctl0,
    input  logic [31:0]      cfg5,
    input  logic [XLEN-1:0]  user_local,
    output logic [XLEN-1:0]  value
);
    logic [XLEN-1:0] cycle_ext;

    // Cycle counter widening: sign extension when the datapath is wider.
    if (XLEN > 32) begin : g_wide
        assign cycle_ext = {{(XLEN-32){cycle[31]}}, cycle};
    end else begin : g_narrow
        assign cycle_ext = cycle[XLEN-1:0];
    end

    // Select the source value for the register number.
    always_comb begin
        unique case (reg_num)
            RN_CPUNUM: value = {{(XLEN-CPUNUM_W){1'b0}}, cpu_num};
            RN_STEP:   value = sync_step;
            RN_CYCLE:  value = cycle_ext;
            RN_RES:    value = cc_res;
            RN_PERF:   value = perf_ctl0;
            RN_XFLAG:  value = {{(XLEN-1){1'b0}}, cfg5[XNP_BIT]};
            RN_ULOCAL: value = user_local;
            default:   value = '0;
        endcase
    end
endmodule

// File: rtl/hwreg_read_unit.sv
// Module: top of the hardware register read unit. Holds the enable mask,
// checks each read request and returns a registered result or an exception.
// Assumes: one request per cycle at most; a mask write in the same cycle as a
// read takes effect for later reads only.
module hwreg_read_unit
    import hwr_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int CPUNUM_W = 10,
    parameter int XNP_BIT  = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_perf_present,
    input  logic            cfg_user_local,
    input  logic            cfg_rev6,
    input  logic            priv_mode,
    input  logic            mask_wr_en,
    input  logic [31:0]     mask_wr_data,
    output logic [31:0]     mask_q,
    input  logic            req_valid,
    input  logic [4:0]      req_reg,
    input  logic [2:0]      req_sel,
    input  logic [31:0]     src_ebase,
    input  logic [XLEN-1:0] src_sync_step,
    input  logic [31:0]     src_cycle,
    input  logic [XLEN-1:0] src_cc_res,
    input  logic [XLEN-1:0] src_perf_ctl0,
    input  logic [31:0]     src_cfg5,
    input  logic [XLEN-1:0] src_user_local,
    output logic            rsp_valid,
    output logic            rsp_ri,
    output logic [XLEN-1:0] rsp_data
);
    hwr_cfg_t        cfg;
    logic            present;
    logic            permit;
    logic [XLEN-1:0] value;
    logic            unused_ebase_hi;

    assign cfg = '{perf_present: cfg_perf_present, user_local: cfg_user_local, rev6: cfg_rev6};
    assign unused_ebase_hi = ^src_ebase[31:CPUNUM_W];

    hwr_enable_mask u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .wr_en   (mask_wr_en),
        .wr_data (mask_wr_data),
        .mask_q  (mask_q)
    );

    hwr_access_check u_check (
        .cfg     (cfg),
        .priv    (priv_mode),
        .mask    (mask_q),
        .reg_num (req_reg),
        .sel     (req_sel),
        .present (present),
        .permit  (permit)
    );

    hwr_value_mux #(.XLEN(XLEN), .CPUNUM_W(CPUNUM_W), .XNP_BIT(XNP_BIT)) u_mux (
        .reg_num    (req_reg),
        .cpu_num    (src_ebase[CPUNUM_W-1:0]),
        .sync_step  (src_sync_step),
        .cycle      (src_cycle),
        .cc_res     (src_cc_res),
        .perf_ctl0  (src_perf_ctl0),
        .cfg5       (src_cfg5),
        .user_local (src_user_local),
        .value      (value)
    );

    // Response pulses: one of valid or exception per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ri    <= 1'b0;
        end else begin
            rsp_valid <= req_valid && permit;
            rsp_ri    <= req_valid && !permit;
        end
    end

    // Result register: loads only on a permitted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data <= '0;
        end else if (req_valid && permit) begin
            rsp_data <= value;
        end
    end

    p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_ri));
    p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || rsp_ri) |-> $past(req_valid));
    p_req_answered_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid || rsp_ri));
    p_ri_keeps_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ri |-> $stable(rsp_data));
    p_no_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !priv_mode && !mask_q[req_reg]) |=> rsp_ri);
    p_perf_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_reg == RN_PERF && req_sel != '0) |=> rsp_ri);
    p_unknown_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_reg > RN_XFLAG && req_reg != RN_ULOCAL) |=> rsp_ri);
    p_present_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !present) |=> !rsp_valid);
endmodule

// File: tb/hwreg_read_unit_bench.sv
module hwreg_read_unit_bench;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_perf_present = 0, cfg_user_local = 0, cfg_rev6 = 0, priv_mode = 0;
    logic            mask_wr_en = 0;
    logic [31:0]     mask_wr_data = '0;
    logic [31:0]     mask_q;
    logic            req_valid = 0;
    logic [4:0]      req_reg = '0;
    logic [2:0]      req_sel = '0;
    logic [31:0]     src_ebase = '0, src_cycle = '0, src_cfg5 = '0;
    logic [XLEN-1:0] src_sync_step = '0, src_cc_res = '0, src_perf_ctl0 = '0, src_user_local = '0;
    logic            rsp_valid, rsp_ri;
    logic [XLEN-1:0] rsp_data;

    int checks = 0;
    int errors = 0;
    logic [31:0]     model_mask = '0;
    logic [XLEN-1:0] model_data = '0;

    always #10 clk = ~clk;

    hwreg_read_unit #(.XLEN(XLEN)) u_hwreg_read_unit (.*);

    function automatic logic [31:0] writable(bit pf, bit ul, bit r6);
        logic [31:0] w = 32'hF;
        if (pf && r6) w[4] = 1'b1;
        if (r6) w[5] = 1'b1;
        if (ul) w[29] = 1'b1;
        return w;
    endfunction

    function automatic bit exists(logic [4:0] rg, logic [2:0] sl, bit ul, bit r6);
        if (rg <= 5'd3) return 1'b1;
        if (rg == 5'd4) return r6 && sl == 3'd0;
        if (rg == 5'd5) return r6;
        if (rg == 5'd29) return ul;
        return 1'b0;
    endfunction

    function automatic logic [XLEN-1:0] ref_value(logic [4:0] rg);
        case (rg)
            5'd0: return {54'd0, src_ebase[9:0]};
            5'd1: return src_sync_step;
            5'd2: return {{32{src_cycle[31]}}, src_cycle};
            5'd3: return src_cc_res;
            5'd4: return src_perf_ctl0;
            5'd5: return {63'd0, src_cfg5[13]};
            5'd29: return src_user_local;
            default: return '0;
        endcase
    endfunction

    function automatic string reg_tag(logic [4:0] rg);
        case (rg)
            5'd0, 5'd1, 5'd3: return "R6";
            5'd2: return "R7";
            5'd4: return "R8";
            5'd5, 5'd29: return "R9";
            default: return "R10";
        endcase
    endfunction

    // One cycle: drive at a falling edge, check at the next falling edge.
    task automatic step(bit wr, logic [31:0] wd, bit pf, bit ul, bit r6, bit pv,
                        bit rq, logic [4:0] rg, logic [2:0] sl, string tag);
        bit exp_v = 0, exp_ri = 0, ok;
        logic [XLEN-1:0] exp_d = model_data;
        cfg_perf_present = pf; cfg_user_local = ul; cfg_rev6 = r6; priv_mode = pv;
        mask_wr_en = wr; mask_wr_data = wd;
        req_valid = rq; req_reg = rg; req_sel = sl;
        if (rq) begin
            ok = exists(rg, sl, ul, r6) && (pv || model_mask[rg]);
            if (ok) begin exp_v = 1; exp_d = ref_value(rg); end
            else exp_ri = 1;
        end
        if (wr) model_mask = wd & writable(pf, ul, r6);
        @(posedge clk);
        @(negedge clk);
        model_data = exp_d;
        checks++;
        if (rsp_valid !== exp_v || rsp_ri !== exp_ri || rsp_data !== exp_d) begin
            errors++;
            $display("FAIL %s response actual v=%0b ri=%0b d=%h expected v=%0b ri=%0b d=%h",
                     tag, rsp_valid, rsp_ri, rsp_data, exp_v, exp_ri, exp_d);
        end
        checks++;
        if (mask_q !== model_mask) begin
            errors++;
            $display("FAIL %s mask actual %h expected %h", tag, mask_q, model_mask);
        end
    endtask

    task automatic randomize_sources();
        src_ebase = $urandom; src_cycle = $urandom; src_cfg5 = $urandom;
        src_sync_step = {$urandom, $urandom}; src_cc_res = {$urandom, $urandom};
        src_perf_ctl0 = {$urandom, $urandom}; src_user_local = {$urandom, $urandom};
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL R11 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240601));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        checks++;
        if (mask_q !== 32'd0 || rsp_valid !== 1'b0 || rsp_ri !== 1'b0 || rsp_data !== '0) begin
            errors++;
            $display("FAIL R1 reset actual mask=%h v=%0b ri=%0b d=%h expected 0", mask_q, rsp_valid, rsp_ri, rsp_data);
        end
        rst_n = 1'b1;

        src_cycle = 32'h8000_0001; src_ebase = 32'hFFFF_F3A5; src_cfg5 = 32'h0000_2000;
        src_perf_ctl0 = 64'h1234_5678_9ABC_DEF0; src_user_local = 64'hCAFE_0000_0000_BEEF;
        src_sync_step = 64'd64; src_cc_res = 64'd2;

        step(0, 0, 0, 0, 0, 0, 1, 5'd2, 3'd0, "R5");             // no right: exception
        step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 5'd0, 3'd0, "R2"); // only 3:0 stick
        step(0, 0, 0, 0, 0, 0, 1, 5'd2, 3'd0, "R7");             // sign extension
        step(1, 32'hFFFF_FFFF, 1, 0, 0, 0, 1, 5'd4, 3'd0, "R3"); // bit4 needs rev6
        step(1, 32'hFFFF_FFFF, 1, 0, 1, 0, 1, 5'd2, 3'd0, "R3"); // read uses old mask
        step(0, 0, 1, 0, 1, 0, 1, 5'd4, 3'd0, "R8");
        step(0, 0, 1, 0, 1, 1, 1, 5'd4, 3'd3, "R8");             // nonzero select
        step(1, 32'hFFFF_FFFF, 0, 1, 0, 0, 1, 5'd5, 3'd0, "R4"); // rev6 absent
        step(0, 0, 0, 1, 0, 0, 1, 5'd29, 3'd0, "R9");
        step(0, 0, 0, 0, 0, 1, 1, 5'd29, 3'd0, "R10");            // no user-local
        step(0, 0, 0, 0, 0, 1, 1, 5'd17, 3'd0, "R10");
        step(0, 0, 0, 0, 1, 1, 1, 5'd5, 3'd0, "R9");
        step(0, 0, 0, 0, 0, 0, 1, 5'd0, 3'd5, "R12");             // select ignored
        step(0, 0, 0, 0, 0, 1, 1, 5'd3, 3'd7, "R6");
        step(0, 0, 0, 0, 0, 1, 0, 5'd1, 3'd0, "R11");             // no request
        step(1, 32'd0, 0, 0, 0, 0, 1, 5'd1, 3'd0, "R5");          // cleared later

        for (int i = 0; i < 3000; i++) begin
            logic [4:0] rg;
            logic [2:0] sl;
            bit pv, wr, rq, ok;
            string tag;
            int pick = $urandom_range(0, 8);
            randomize_sources();
            case (pick)
                7: rg = 5'd29;
                8: rg = 5'($urandom);
                default: rg = 5'(pick % 6);
            endcase
            sl = ($urandom_range(0, 1) != 0) ? 3'd0 : 3'($urandom);
            pv = ($urandom_range(0, 3) == 0);
            wr = ($urandom_range(0, 4) == 0);
            rq = ($urandom_range(0, 5) != 0);
            ok = pv || model_mask[rg];
            tag = !rq ? "R11" : (!ok ? "R5" : reg_tag(rg));
            if (wr) tag = {tag, "/R2"};
            step(wr, $urandom, 1'($urandom), 1'($urandom), 1'($urandom), pv, rq, rg, sl, tag);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule